// File: doc/BRIEF.md
# Asynchronous SRAM Port Access Sequencer

This block is a clocked controller for one port of an asynchronous 4K x 8 static RAM. On the user side it takes one request at a time over a valid/ready handshake. A request carries an address, write data and a write flag. For each request the block produces chip enable, read/write and output enable strobes in a safe order, together with a stable address and a write data bus that has its own drive enable. Read data comes back as a single-cycle response pulse.

Every analog interval of the RAM is a parameter given in nanoseconds, along with the system clock period. The block rounds each interval up to whole clock cycles, with a minimum of one cycle.

A write runs through four phases:
- a setup cycle in which the address and data are presented with the strobes inactive;
- a write overlap, during which chip enable and read/write are both low;
- a hold phase with the strobes released and the data still driven;
- optional padding until the minimum write cycle time has passed.

Output enable stays high for the whole write, so the short write pulse can be used. A read holds chip enable and output enable low for the access latency, captures the data at the end of it, and then pads out to the read cycle time.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the request inputs are not looked at. There is no way to stall the response, so a user must take `rsp_valid` when it appears.

Top module: `sram_port_seq`

## Requirements
- R1: While reset is held and after it is released, `mem_ce_n`, `mem_rw_n` and `mem_oe_n` are 1, `mem_wdata_en` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: After an accepted request, `req_ready` stays 0 until the operation is over. Request inputs presented while `req_ready` is 0 have no effect on the address used, the data written or the data returned.
- R3: A write pulls `mem_rw_n` to 0 for exactly PW cycles, in one contiguous run, and only while `mem_ce_n` is 0. PW is the largest of the rounded write pulse, data-to-end and address-to-end intervals.
- R4: `mem_addr` changes only in a cycle where `mem_rw_n` was 1 before and after the change. During a write it equals the request address.
- R5: `mem_wdata_en` is 1 throughout the write overlap, with `mem_wdata` equal to the request data. After `mem_rw_n` returns to 1, the data stays driven and unchanged for exactly HOLD cycles (rounded hold time, at least 1).
- R6: `mem_oe_n` is 1 whenever `mem_rw_n` is 0 or `mem_wdata_en` is 1. `mem_oe_n` falls only after a cycle in which `mem_wdata_en` was 0.
- R7: A read holds `mem_ce_n` and `mem_oe_n` at 0 with `mem_rw_n` at 1 for exactly AC cycles. AC is the largest of the rounded address, chip-enable and output-enable access times. The bus is captured on the edge that ends the last of those cycles. `rsp_valid` is 1 for the following single cycle, with `rsp_rdata` carrying the captured byte.
- R8: `req_ready` stays 0 for max(WC, 1+PW+HOLD) cycles after a write is accepted, and for max(RC, AC) cycles after a read is accepted. WC and RC are the rounded write and read cycle times.
- R9: Each interval in nanoseconds becomes ceil(ns / clock period) cycles, with a floor of 1. Data written at an address is returned by a later read of that address, including at addresses 0 and 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Request address |
| req_wdata | input | 8 | Request write data |
| rsp_valid | output | 1 | Single-cycle read response strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 12 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_rw_n | output | 1 | RAM read/write, 0 = write |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_wdata | output | 8 | Data toward the RAM |
| mem_wdata_en | output | 1 | Drive enable for `mem_wdata` |
| mem_rdata | input | 8 | Data from the RAM |

## Verification
The bench's RAM model only presents valid data after the access window has run its full length, so capturing one cycle early shows up as a wrong byte. Directed writes and reads at addresses 0 and 4095 with data 00 and FF test the boundaries and the all-zero and all-one patterns. A write followed at once by a read of the same address tests bus turnaround and write-to-read ordering. Random mixed traffic over a small address window produces repeated hits on the same addresses, which separates a correct write path from stale data. During every busy phase the bench drives conflicting request values, which shows whether anything is sampled outside acceptance.

// File: rtl/sram_port_seq_pkg.sv
package sram_port_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4,
    ST_PAD  = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic rw_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STB_IDLE = '{ce_n: 1'b1, rw_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic int cyc_of(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobes_of(input seq_state_t s);
    strobe_t t;
    t = STB_IDLE;
    case (s)
      ST_WSET: t = '{ce_n: 1'b0, rw_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_WPUL: t = '{ce_n: 1'b0, rw_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
      ST_WHLD: t = '{ce_n: 1'b1, rw_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_RACC: t = '{ce_n: 1'b0, rw_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
      default: t = STB_IDLE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R8: the interval counter never wraps below zero
  p_timer_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_port_seq_pkg::*;
#(
  parameter int PW    = 1,
  parameter int HOLD  = 1,
  parameter int AC    = 1,
  parameter int WPAD  = 0,
  parameter int RPAD  = 0,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cap_en,
  output logic             ce_n,
  output logic             rw_n,
  output logic             oe_n,
  output logic             drv
);
  localparam logic [CNT_W-1:0] V_PW   = CNT_W'(PW - 1);
  localparam logic [CNT_W-1:0] V_HOLD = CNT_W'(HOLD - 1);
  localparam logic [CNT_W-1:0] V_AC   = CNT_W'(AC - 1);
  localparam logic [CNT_W-1:0] V_WPAD = CNT_W'((WPAD > 0) ? WPAD - 1 : 0);
  localparam logic [CNT_W-1:0] V_RPAD = CNT_W'((RPAD > 0) ? RPAD - 1 : 0);

  seq_state_t state_q, state_nx;
  strobe_t    stb_q;

  always_comb begin
    state_nx = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_nx = ST_WSET;
        end else begin
          state_nx = ST_RACC;
          tmr_val  = V_AC;
        end
      end
      ST_WSET: if (tmr_zero) begin
        state_nx = ST_WPUL; tmr_load = 1'b1; tmr_val = V_PW;
      end
      ST_WPUL: if (tmr_zero) begin
        state_nx = ST_WHLD; tmr_load = 1'b1; tmr_val = V_HOLD;
      end
      ST_WHLD: if (tmr_zero) begin
        if (WPAD > 0) begin
          state_nx = ST_PAD; tmr_load = 1'b1; tmr_val = V_WPAD;
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_RACC: if (tmr_zero) begin
        cap_en = 1'b1;
        if (RPAD > 0) begin
          state_nx = ST_PAD; tmr_load = 1'b1; tmr_val = V_RPAD;
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_PAD: if (tmr_zero) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  // strobes are registered from the next state so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stb_q   <= STB_IDLE;
    end else begin
      state_q <= state_nx;
      stb_q   <= strobes_of(state_nx);
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ce_n = stb_q.ce_n;
  assign rw_n = stb_q.rw_n;
  assign oe_n = stb_q.oe_n;
  assign drv  = stb_q.drv;

  // R3: write overlap only with chip enable low
  p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> !ce_n);
  // R6: output enable stays high during a write and while the bus is driven
  p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_n || drv) |-> oe_n);
  // R6: one undriven cycle before output enable falls
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(drv));
  // R2: not ready while strobes are active
  p_busy_when_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n || drv) |-> !req_ready);
endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_data <= din;
    end
  end

  // R7: the response is a single-cycle pulse
  p_rsp_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_port_seq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int T_CLK_NS = 20,
  parameter int T_WC_NS  = 20,
  parameter int T_WP_NS  = 15,
  parameter int T_AW_NS  = 15,
  parameter int T_DW_NS  = 15,
  parameter int T_DH_NS  = 0,
  parameter int T_RC_NS  = 20,
  parameter int T_AA_NS  = 20,
  parameter int T_ACE_NS = 20,
  parameter int T_AOE_NS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_rw_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_en,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW    = imax(cyc_of(T_WP_NS, T_CLK_NS),
                              imax(cyc_of(T_DW_NS, T_CLK_NS), cyc_of(T_AW_NS, T_CLK_NS)));
  localparam int HOLD  = cyc_of(T_DH_NS, T_CLK_NS);
  localparam int WC    = cyc_of(T_WC_NS, T_CLK_NS);
  localparam int RC    = cyc_of(T_RC_NS, T_CLK_NS);
  localparam int AC    = imax(cyc_of(T_AA_NS, T_CLK_NS),
                              imax(cyc_of(T_ACE_NS, T_CLK_NS), cyc_of(T_AOE_NS, T_CLK_NS)));
  localparam int WBASE = 1 + PW + HOLD;
  localparam int WPAD  = (WC > WBASE) ? WC - WBASE : 0;
  localparam int RPAD  = (RC > AC) ? RC - AC : 0;
  localparam int MAXC  = imax(imax(PW, HOLD), imax(AC, imax(WPAD, RPAD)));
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             accept;
  logic             tmr_load, tmr_zero, cap_en;
  logic [CNT_W-1:0] tmr_val;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  sram_seq_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_seq_fsm #(
    .PW(PW), .HOLD(HOLD), .AC(AC), .WPAD(WPAD), .RPAD(RPAD), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .cap_en(cap_en), .ce_n(mem_ce_n), .rw_n(mem_rw_n),
    .oe_n(mem_oe_n), .drv(mem_wdata_en)
  );

  sram_seq_rdcap #(.DW(DW)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .din(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R4: the address moves only with read/write high on both sides
  p_addr_moves_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_rw_n && $past(mem_rw_n)));
  // R5: data driven and steady across the overlap
  p_data_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rw_n |-> (mem_wdata_en && $stable(mem_wdata)));
  // R5: data still driven on the cycle the overlap ends
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_rw_n) && $past(!mem_ce_n)) |-> (mem_wdata_en && $stable(mem_wdata)));
endmodule

// File: tb/sram_port_seq_test.sv
module sram_port_seq_test;
  localparam int CLK_NS = 20;
  localparam int WC_NS = 110, WP_NS = 45, AW_NS = 50, DW_NS = 30, DH_NS = 5;
  localparam int RC_NS = 90, AA_NS = 50, ACE_NS = 45, AOE_NS = 30;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected counts from the requirements (R9 rounding)
  localparam int E_PW   = mx(cyc(WP_NS), mx(cyc(DW_NS), cyc(AW_NS)));
  localparam int E_HOLD = cyc(DH_NS);
  localparam int E_AC   = mx(cyc(AA_NS), mx(cyc(ACE_NS), cyc(AOE_NS)));
  localparam int E_WBSY = mx(cyc(WC_NS), 1 + E_PW + E_HOLD);
  localparam int E_RBSY = mx(cyc(RC_NS), E_AC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_rw_n, mem_oe_n, mem_wdata_en;
  logic [7:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [11:0] mem_addr;

  int n_chk = 0, n_bad = 0, viol_turn = 0;

  always #10 clk = ~clk;

  sram_port_seq #(
    .T_CLK_NS(CLK_NS), .T_WC_NS(WC_NS), .T_WP_NS(WP_NS), .T_AW_NS(AW_NS),
    .T_DW_NS(DW_NS), .T_DH_NS(DH_NS), .T_RC_NS(RC_NS), .T_AA_NS(AA_NS),
    .T_ACE_NS(ACE_NS), .T_AOE_NS(AOE_NS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_rw_n(mem_rw_n), .mem_oe_n(mem_oe_n),
    .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata)
  );

  // RAM model: data valid only once the read window has lasted AC cycles
  logic [7:0] ram [4096];
  logic [7:0] exp_mem [4096];
  int rd_run = 0;
  logic prev_drv = 1'b0;

  assign mem_rdata = (!mem_ce_n && !mem_oe_n && mem_rw_n && rd_run >= E_AC - 1)
                     ? ram[mem_addr] : 8'hEE;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_rw_n && mem_wdata_en) ram[mem_addr] <= mem_wdata;
    rd_run <= (!mem_ce_n && !mem_oe_n && mem_rw_n) ? rd_run + 1 : 0;
  end

  always @(negedge clk) begin
    if (rst_n && !mem_oe_n && (mem_wdata_en || prev_drv)) viol_turn++;
    prev_drv = mem_wdata_en;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    int busy, wlow, hold, bad;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = ~a; req_wdata = ~d; req_write = 1'b0;   // R2 junk while busy
    busy = 0; wlow = 0; hold = 0; bad = 0;
    while (!req_ready) begin
      busy++;
      if (!mem_rw_n) begin
        wlow++;
        if (mem_ce_n || mem_addr != a || mem_wdata != d || !mem_wdata_en || !mem_oe_n) bad++;
      end else if (wlow > 0 && mem_wdata_en) begin
        hold++;
        if (mem_wdata != d) bad++;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    exp_mem[a] = d;
    chk(busy == E_WBSY, "R8 write busy", busy, E_WBSY);
    chk(wlow == E_PW, "R3 write pulse", wlow, E_PW);
    chk(hold == E_HOLD, "R5 hold", hold, E_HOLD);
    chk(bad == 0, "R4 addr/data during write", bad, 0);
  endtask

  task automatic do_read(input logic [11:0] a);
    int busy, rsp_at, win, pulses;
    logic [7:0] got;
    got = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = $urandom;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = ~a; req_write = 1'b1;   // R2 junk while busy
    busy = 0; rsp_at = 0; win = 0; pulses = 0;
    while (!req_ready) begin
      busy++;
      if (rsp_valid) begin rsp_at = busy; got = rsp_rdata; pulses++; end
      if (!mem_ce_n && !mem_oe_n && mem_rw_n) win++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (rsp_valid) begin rsp_at = busy + 1; got = rsp_rdata; pulses++; end
    chk(busy == E_RBSY, "R8 read busy", busy, E_RBSY);
    chk(win == E_AC, "R7 read window", win, E_AC);
    chk(rsp_at == E_AC + 1 && pulses == 1, "R7 response cycle", rsp_at, E_AC + 1);
    chk(got == exp_mem[a], "R9 read data", got, exp_mem[a]);
  endtask

  function automatic logic [11:0] pick_addr();
    int r;
    r = $urandom_range(0, 9);
    if (r == 0) return 12'h000;
    if (r == 1) return 12'hFFF;
    return 12'($urandom_range(0, 63));
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4096; i++) begin
      ram[i] = 8'(i ^ (i >> 4));
      exp_mem[i] = 8'(i ^ (i >> 4));
    end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_rw_n && mem_oe_n, "R1 strobes in reset",
        {mem_ce_n, mem_rw_n, mem_oe_n}, 7);
    chk(!mem_wdata_en && !rsp_valid, "R1 drive/rsp in reset", mem_wdata_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_rw_n && mem_oe_n && !mem_wdata_en,
        "R1 idle after reset", req_ready, 1);

    // directed corners
    do_write(12'h000, 8'hFF);
    do_read(12'h000);            // turnaround, R6
    do_write(12'hFFF, 8'h00);
    do_read(12'hFFF);
    do_read(12'h123);            // never written: initial pattern
    do_write(12'h040, 8'hA5);
    do_write(12'h040, 8'h5A);    // overwrite
    do_read(12'h040);

    for (int i = 0; i < 160; i++) begin
      logic [11:0] a;
      a = pick_addr();
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else do_read(a);
    end

    chk(viol_turn == 0, "R6 oe vs drive turnaround", viol_turn, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule